// File: doc/BRIEF.md
# SDRAM Read Sequencer with Open-Row Page Access

This block turns read requests from a simple requester into the command sequence for one SDRAM bank, and collects the data burst that comes back. A request carries a row and a column. If no row is open, the block activates the requested row. It waits the row-to-column delay, issues a column read, waits the CAS latency and then captures a burst of consecutive words. Each captured word is returned with a valid strobe and the column it belongs to.

After an access the row stays open. A later request to the same row goes straight to the column read, which is page-mode access. A request to another row first closes the bank with a precharge. It waits the precharge time before it activates the new row.

The requester uses a valid/ready handshake. One access is in flight at a time. The burst length, the three delays and the address widths are parameters. A one-bit mode input selects sequential wrap-around or interleaved burst order, and it is taken when the request is accepted.

Top module: `sdram_rd_seq`

## Requirements
- R1: After reset, req_ready is 1, rd_valid is 0 and the command pins show NOP.
- R2: Commands are driven on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} as NOP=0111, ACTIVATE=0011, READ=0101, PRECHARGE=0010, and every cycle with no command shows NOP.
- R3: When no row is open, ACTIVATE with the row on sd_addr is driven in the cycle after acceptance. READ with the column on sd_addr follows T_RCD clocks after ACTIVATE.
- R4: When the requested row is the open row, READ with the column is driven in the cycle after acceptance, with no ACTIVATE or PRECHARGE.
- R5: When another row is open, PRECHARGE is driven in the cycle after acceptance. ACTIVATE of the new row comes T_RP clocks later, and READ comes T_RCD clocks after that.
- R6: The first burst word is taken from sd_dq CAS_LAT clocks after READ, and the following words on the next BL-1 clocks. Each word appears on rd_data with rd_valid high one clock after it was on sd_dq, with the BL valid cycles back to back.
- R7: With req_ilv=0 at acceptance, burst word k carries column (start with its low log2(BL) bits replaced by (low + k) mod BL). This is reported on rd_col.
- R8: With req_ilv=1 at acceptance, burst word k carries column (start with its low log2(BL) bits replaced by low XOR k). Request fields that change after acceptance have no effect on the access.
- R9: req_ready is low from the cycle after acceptance until the cycle in which rd_valid carries the last burst word. In that cycle it is high again, and a new request may be accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Starting column of the request |
| req_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Row or column address for the command |
| sd_dq | input | DATA_W | Read data from the memory |
| rd_valid | output | 1 | Returned word valid |
| rd_data | output | DATA_W | Returned word |
| rd_col | output | COL_W | Column of the returned word |

## Verification
The assertions assume that the delay parameters are at least 1. They also assume that BL is a power of two of at least 2 and smaller than 2**COL_W, and that reset is applied before the first request. They make no assumption about the sd_dq contents, so the timing properties hold whatever the memory returns. The stimulus uses the default parameters and changes inputs only on the falling clock edge. It draws rows from a small pool so that hits, misses and the first closed-bank access all occur. After each acceptance it scrambles the request fields and the mode input, so any late sampling of them would show up.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_ACT  = 4'b0011,
    CMD_READ = 4'b0101,
    CMD_PRE  = 4'b0010
  } sd_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ACT,
    S_READ,
    S_WAIT,
    S_CAP
  } seq_state_e;

  // A gap of d clocks between two commands needs a wait state only when d > 1
  function automatic bit needs_wait(input int unsigned d);
    return d > 1;
  endfunction

  // Counter preset for the wait state: exits when the counter reaches zero
  function automatic int unsigned wait_preset(input int unsigned d);
    return (d > 1) ? d - 2 : 0;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sdram_row_track.sv
module sdram_row_track #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_fire,
  input  logic             pre_fire,
  input  logic             rd_fire,
  input  logic [ROW_W-1:0] act_row,
  input  logic [ROW_W-1:0] req_row,
  output logic             row_open,
  output logic             row_hit
);

  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_fire) begin
      open_q <= 1'b1;
      row_q  <= act_row;
    end else if (pre_fire) begin
      open_q <= 1'b0;
    end
  end

  assign row_open = open_q;
  assign row_hit  = open_q && (row_q == req_row);

  // R4
  read_needs_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |-> row_open);

  // R5
  act_needs_closed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |-> !row_open);

  // R5
  pre_needs_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_fire |-> row_open);

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int BL     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [COL_W-1:0]  start_col,
  input  logic              ilv,
  input  logic [DATA_W-1:0] dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [COL_W-1:0]  rd_col,
  output logic              rd_last,
  output logic              beat_last
);

  localparam int               LB   = $clog2(BL);
  localparam logic [COL_W-1:0] MASK = COL_W'(BL - 1);

  logic [LB-1:0] beat;

  // Column of burst word b: upper bits kept, low bits wrapped or XORed
  function automatic logic [COL_W-1:0] beat_col(input logic [COL_W-1:0] s,
                                                input logic [LB-1:0]    b,
                                                input logic             il);
    logic [COL_W-1:0] bx;
    logic [COL_W-1:0] off;
    bx  = COL_W'(b);
    off = il ? ((s ^ bx) & MASK) : ((s + bx) & MASK);
    return (s & ~MASK) | off;
  endfunction

  assign beat_last = cap_en && (beat == LB'(BL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat     <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
      rd_col   <= '0;
    end else begin
      rd_valid <= cap_en;
      rd_last  <= beat_last;
      if (cap_en) begin
        rd_data <= dq;
        rd_col  <= beat_col(start_col, beat, ilv);
        beat    <= beat + 1'b1;
      end else begin
        beat <= '0;
      end
    end
  end

  // R7
  burst_stays_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) && !$past(rd_last)) |->
      ((rd_col & ~MASK) == ($past(rd_col) & ~MASK)));

  // R6
  burst_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |=> rd_valid);

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int DATA_W  = 16,
  parameter int BL      = 4,
  parameter int T_RCD   = 2,
  parameter int CAS_LAT = 2,
  parameter int T_RP    = 2,
  parameter int ADDR_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_ilv,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  input  logic [DATA_W-1:0] sd_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [COL_W-1:0]  rd_col
);

  localparam int MAXD = max3(T_RCD, CAS_LAT, T_RP);
  localparam int WCW  = $clog2(MAXD + 1);
  localparam int CKW  = $clog2(MAXD + BL + 4) + 1;
  localparam logic [CKW-1:0] CK_SAT = '1;

  seq_state_e       state, ret_state;
  logic [WCW-1:0]   wcnt;
  logic [ROW_W-1:0] lat_row;
  logic [COL_W-1:0] lat_col;
  logic             lat_ilv;
  sd_cmd_e          cmd;

  // Named internal events
  logic acc_fire, act_fire, pre_fire, rd_fire, cap_en;
  logic row_open, row_hit, beat_last, rd_last;

  assign req_ready = (state == S_IDLE);
  assign acc_fire  = req_valid && req_ready;
  assign act_fire  = (state == S_ACT);
  assign pre_fire  = (state == S_PRE);
  assign rd_fire   = (state == S_READ);
  assign cap_en    = (state == S_CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ret_state <= S_IDLE;
      wcnt      <= '0;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_ilv   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          lat_row <= req_row;
          lat_col <= req_col;
          lat_ilv <= req_ilv;
          if (row_hit)       state <= S_READ;
          else if (row_open) state <= S_PRE;
          else               state <= S_ACT;
        end
        S_PRE: if (needs_wait(T_RP)) begin
          state     <= S_WAIT;
          ret_state <= S_ACT;
          wcnt      <= WCW'(wait_preset(T_RP));
        end else begin
          state <= S_ACT;
        end
        S_ACT: if (needs_wait(T_RCD)) begin
          state     <= S_WAIT;
          ret_state <= S_READ;
          wcnt      <= WCW'(wait_preset(T_RCD));
        end else begin
          state <= S_READ;
        end
        S_READ: if (needs_wait(CAS_LAT)) begin
          state     <= S_WAIT;
          ret_state <= S_CAP;
          wcnt      <= WCW'(wait_preset(CAS_LAT));
        end else begin
          state <= S_CAP;
        end
        S_WAIT: if (wcnt == '0) state <= ret_state;
                else            wcnt  <= wcnt - 1'b1;
        S_CAP:  if (beat_last)  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // Command and address drive
  always_comb begin
    cmd     = CMD_NOP;
    sd_addr = '0;
    case (state)
      S_PRE:  cmd = CMD_PRE;
      S_ACT: begin
        cmd     = CMD_ACT;
        sd_addr = ADDR_W'(lat_row);
      end
      S_READ: begin
        cmd     = CMD_READ;
        sd_addr = ADDR_W'(lat_col);
      end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  sdram_row_track #(.ROW_W(ROW_W)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_fire (act_fire),
    .pre_fire (pre_fire),
    .rd_fire  (rd_fire),
    .act_row  (lat_row),
    .req_row  (req_row),
    .row_open (row_open),
    .row_hit  (row_hit)
  );

  sdram_rd_capture #(.COL_W(COL_W), .DATA_W(DATA_W), .BL(BL)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .start_col (lat_col),
    .ilv       (lat_ilv),
    .dq        (sd_dq),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_col    (rd_col),
    .rd_last   (rd_last),
    .beat_last (beat_last)
  );

  // Gap counters used only by the assertions below
  logic [CKW-1:0] since_act, since_pre, since_rd;
  logic           act_pend, pre_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= CK_SAT;
      since_pre <= CK_SAT;
      since_rd  <= CK_SAT;
      act_pend  <= 1'b0;
      pre_pend  <= 1'b0;
    end else begin
      since_act <= act_fire ? CKW'(1) : (since_act == CK_SAT ? since_act : since_act + 1'b1);
      since_pre <= pre_fire ? CKW'(1) : (since_pre == CK_SAT ? since_pre : since_pre + 1'b1);
      since_rd  <= rd_fire  ? CKW'(1) : (since_rd  == CK_SAT ? since_rd  : since_rd  + 1'b1);
      if (act_fire)      act_pend <= 1'b1;
      else if (rd_fire)  act_pend <= 1'b0;
      if (pre_fire)      pre_pend <= 1'b1;
      else if (act_fire) pre_pend <= 1'b0;
    end
  end

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !req_ready);

  // R3
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && act_pend) |-> (since_act == CKW'(T_RCD)));

  // R5
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_fire && pre_pend) |-> (since_pre == CKW'(T_RP)));

  // R6
  cas_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (since_rd == CKW'(CAS_LAT + 1)));

  // R9
  ready_only_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && rd_valid) |-> rd_last);

  // R2
  one_cmd_per_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP) || (CAS_LAT == 1) || (T_RCD == 1) || (T_RP == 1));

endmodule

// File: tb/sdram_rd_seq_tb.sv
module sdram_rd_seq_tb;

  localparam int ROW_W = 12, COL_W = 8, DATA_W = 16, BL = 4;
  localparam int T_RCD = 2, CAS_LAT = 2, T_RP = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011,
                         C_RD  = 4'b0101, C_PRE = 4'b0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ilv = 1'b0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0] sd_addr;
  logic [DATA_W-1:0] sd_dq = 16'hdead;
  logic rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [COL_W-1:0] rd_col;

  int checks = 0, failures = 0;
  bit done = 0;
  bit exp_open = 0;
  logic [ROW_W-1:0] exp_row = '0;

  always #5 clk = ~clk;

  sdram_rd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BL(BL),
                 .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_RP(T_RP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_ilv(req_ilv),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_dq(sd_dq),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_col(rd_col));

  function automatic logic [15:0] mem_word(input logic [11:0] r, input logic [7:0] c);
    return {r[7:0] ^ 8'ha5, c ^ 8'h3c};
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input int k, input bit il);
    int lo, off;
    lo  = s % BL;
    off = il ? (lo ^ k) : ((lo + k) % BL);
    return 8'(s - lo + off);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // Called at a falling edge with req_ready high
  task automatic do_read(input logic [11:0] row, input logic [7:0] col, input bit il);
    int kind, rc, last, k;
    bit c_ok = 1, r_ok = 1, d_ok = 1;
    logic [31:0] c_got = 0, c_exp = 0, r_got = 0, r_exp = 0, d_got = 0, d_exp = 0;
    logic [3:0] got, expc;
    string ctag;
    kind = !exp_open ? 0 : (exp_row == row) ? 1 : 2;
    rc   = (kind == 1) ? 1 : (kind == 0) ? 1 + T_RCD : 1 + T_RP + T_RCD;
    last = rc + CAS_LAT + BL;
    ctag = (kind == 0) ? "R2 R3" : (kind == 1) ? "R2 R4" : "R2 R5";
    req_valid = 1; req_row = row; req_col = col; req_ilv = il;
    for (int i = 1; i <= last; i++) begin
      @(negedge clk);
      if (i == 1) begin
        req_valid = 0; req_row = ~row; req_col = ~col; req_ilv = ~il;
      end
      got  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      expc = C_NOP;
      if (kind == 2 && i == 1)         expc = C_PRE;
      if (kind == 2 && i == 1 + T_RP)  expc = C_ACT;
      if (kind == 0 && i == 1)         expc = C_ACT;
      if (i == rc)                     expc = C_RD;
      if (c_ok && (got != expc ||
          (expc == C_ACT && sd_addr != row) ||
          (expc == C_RD && sd_addr != {4'h0, col}))) begin
        c_ok = 0; c_got = {i[11:0], got, sd_addr}; c_exp = {i[11:0], expc, 12'h0};
      end
      if (r_ok && req_ready != (i == last)) begin
        r_ok = 0; r_got = {i, 1'b0} | req_ready; r_exp = {i, 1'b0} | (i == last);
      end
      k = i - rc - CAS_LAT - 1;
      if (d_ok) begin
        if (k >= 0 && k < BL) begin
          if (!rd_valid || rd_data != mem_word(row, exp_col(col, k, il)) ||
              rd_col != exp_col(col, k, il)) begin
            d_ok = 0; d_got = {rd_valid, 7'h0, rd_col, rd_data};
            d_exp = {8'h80, exp_col(col, k, il), mem_word(row, exp_col(col, k, il))};
          end
        end else if (rd_valid) begin
          d_ok = 0; d_got = {1'b1, 15'h0, 16'(i)}; d_exp = 0;
        end
      end
      k = i - rc - CAS_LAT;
      sd_dq = (k >= 0 && k < BL) ? mem_word(row, exp_col(col, k, il)) : 16'hdead;
    end
    check(c_ok, ctag, "command sequence (cycle,cmd,addr)", c_got, c_exp);
    check(r_ok, "R9", "ready window (cycle,ready)", r_got, r_exp);
    check(d_ok, il ? "R6 R8" : "R6 R7", "burst (valid,col,data)", d_got, d_exp);
    exp_open = 1;
    exp_row  = row;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [11:0] pool [3];
    seed = $urandom(32'd4711);
    pool[0] = 12'h012; pool[1] = 12'h345; pool[2] = 12'h9ab;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    check(rd_valid == 1'b0, "R1", "rd_valid after reset", 32'(rd_valid), 0);
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "cmd after reset",
          32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 32'(C_NOP));
    // Directed: closed bank, hit, wrap at block end, interleave, miss, column at top
    do_read(12'h123, 8'h07, 1'b0);   // R3, R7 wrap inside block 4..7
    do_read(12'h123, 8'h42, 1'b1);   // R4, R8
    do_read(12'h123, 8'hff, 1'b0);   // R4, R7 wrap without carry at top column
    do_read(12'h456, 8'h10, 1'b0);   // R5
    do_read(12'h456, 8'h03, 1'b1);   // R4, R8 start at block end
    do_read(12'h789, 8'hfd, 1'b1);   // R5, R8
    // Random mix of hits and misses
    for (int n = 0; n < 40; n++) begin
      seed = $urandom;
      do_read(pool[seed % 3], 8'(seed >> 4), seed[12]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule